// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Translator

This block sits behind a read-only window of the system address map. Each read request accepted on its request channel becomes one SPI flash read transaction: chip select goes low, an opcode byte and a configurable number of address bytes are shifted out on one lane, an optional dummy stretch follows with all lanes released, and then a full data word is gathered on one, two or four lanes. The word goes back on a response channel, and chip select is released. A packed 32-bit setup input sets the opcode, the address length, the dummy length and the data lane count. A one-bit mode input chooses who owns the SPI pins: this translator, or an external command engine whose pin signals are passed through unchanged.

The request channel (`rd_valid`/`rd_ready`) takes one read at a time. `rd_ready` is high only while the block is idle, so a requester holding `rd_valid` is stalled for the whole flash transaction and for as long as the response is unconsumed. The response channel (`rsp_valid`/`rsp_ready`) holds data and error flag steady until the consumer takes them. A read that arrives while the translator does not own the pins, or while the setup word is all zero, is answered at once with an error and no SPI activity. SCLK idles low; output data changes on falling SCLK edges and input data is sampled on rising edges. Each SCLK half period lasts `SCLK_HALF` clock cycles.

Top module: `mmspi_read_xlate`

## Requirements
- R1: `rd_ready` is high only while no access is in flight and no response is pending. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_err` hold their values.
- R2: An access starts with the opcode `cfg_setup[7:0]`, sent most significant bit first on `spi_io_out[0]`. It is followed by the low N bytes of `rd_addr`, most significant byte first, where N = `cfg_setup[9:8]`. Only `spi_io_oe[0]` is ever driven by the translator.
- R3: After the address, the access spends `cfg_setup[11:10]`*8 + `cfg_setup[28:24]` SCLK cycles in the dummy stretch with `spi_io_oe` all zero. The total SCLK count of an access is 8 + 8N + dummy + 32/lanes.
- R4: `cfg_setup[13:12]` selects the data lanes. 0 and 2 mean one lane sampled on `spi_io_in[1]`. 1 means two lanes, with `spi_io_in[1]` the higher bit of each pair. 3 means four lanes, with `spi_io_in[3]` the highest bit. Each byte arrives most significant bit first.
- R5: Four bytes are gathered per access, and the first byte received lands in `rsp_data[7:0]` (little-endian).
- R6: `spi_cs_n` falls exactly once per accepted access and is high again by the time `rsp_valid` rises. While the translator owns the pins and is idle, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R7: A read accepted while `cfg_mm_en` is 0 gets `rsp_err`=1 and `rsp_data`=0, and `spi_cs_n` never falls.
- R8: A read accepted while `cfg_setup` is all zero gets the same error response with no SPI activity.
- R9: With `cfg_mm_en`=0 and no access in flight, `spi_sclk`, `spi_cs_n`, `spi_io_out` and `spi_io_oe` equal the `cmd_*` inputs.
- R10: Clearing `cfg_mm_en` during an access does not take the pins away. The access completes with correct data, and the command engine gets the pins once chip select is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_setup | input | 32 | Packed read setup word |
| cfg_mm_en | input | 1 | 1: translator owns the SPI pins |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted when high with rd_valid |
| rd_addr | input | 24 | Flash byte address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed when high with rsp_valid |
| rsp_data | output | DATA_W | Read word, little-endian |
| rsp_err | output | 1 | Access refused |
| cmd_sclk | input | 1 | Command engine SCLK |
| cmd_cs_n | input | 1 | Command engine chip select |
| cmd_io_out | input | 4 | Command engine lane outputs |
| cmd_io_oe | input | 4 | Command engine lane enables |
| spi_sclk | output | 1 | SPI clock pin |
| spi_cs_n | output | 1 | SPI chip select pin |
| spi_io_out | output | 4 | SPI lane output values |
| spi_io_oe | output | 4 | SPI lane output enables |
| spi_io_in | input | 4 | SPI lane input values |

## Verification
The hardest situation to reach is a change of pin ownership while a flash transaction is half done. It needs the mode input to fall while chip select is low, with the command engine inputs set to values that would visibly differ. The bench starts a single-lane read, which is the longest kind. It waits until chip select has been low for several cycles, then clears the mode input with the command chip select held high. It checks that the pin stays low and that the returned word still matches the flash model. Dummy lengths that combine whole bytes with extra bits are reached through a quad setup whose bit-count field is non-zero, and the total rising-edge count of each access is checked against the formula.

// File: rtl/mmspi_pkg.sv
package mmspi_pkg;

  localparam int MAX_ADDR_BYTES = 3;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_TX,
    XS_DUMMY,
    XS_RX,
    XS_RESP
  } xs_state_e;

  // Fields of the setup word that shape a read.
  typedef struct packed {
    logic [7:0] rd_op;
    logic [1:0] addr_bytes;
    logic [1:0] dummy_bytes;
    logic [1:0] rd_type;
    logic [4:0] dummy_bits;
  } rd_cfg_t;

  function automatic rd_cfg_t decode_setup(input logic [31:0] w);
    rd_cfg_t c;
    c.rd_op       = w[7:0];
    c.addr_bytes  = w[9:8];
    c.dummy_bytes = w[11:10];
    c.rd_type     = w[13:12];
    c.dummy_bits  = w[28:24];
    return c;
  endfunction

  // log2 of the data lane count: 0 single, 1 dual, 2 quad.
  function automatic logic [1:0] lane_lg(input logic [1:0] t);
    case (t)
      2'd1:    return 2'd1;
      2'd3:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/mmspi_sclk_div.sv
module mmspi_sclk_div #(
  parameter int SCLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

  logic [DIV_W-1:0] div_q;

  assign tick = run && (div_q == DIV_W'(SCLK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!run || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/mmspi_rx_gather.sv
module mmspi_rx_gather #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sample,
  input  logic [1:0]        lane_lg,
  input  logic [3:0]        io_in,
  output logic [DATA_W-1:0] word
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (clr) begin
      sr_q <= '0;
    end else if (sample) begin
      case (lane_lg)
        2'd0:    sr_q <= {sr_q[DATA_W-2:0], io_in[1]};
        2'd1:    sr_q <= {sr_q[DATA_W-3:0], io_in[1:0]};
        default: sr_q <= {sr_q[DATA_W-5:0], io_in[3:0]};
      endcase
    end
  end

  // First byte shifted in ends up on top; place it in the lowest lane.
  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign word[8*b +: 8] = sr_q[DATA_W-8*(b+1) +: 8];
  end
endmodule

// File: rtl/mmspi_pin_mux.sv
module mmspi_pin_mux (
  input  logic       sel_mm,
  input  logic       mm_sclk,
  input  logic       mm_cs_n,
  input  logic [3:0] mm_io_out,
  input  logic [3:0] mm_io_oe,
  input  logic       cmd_sclk,
  input  logic       cmd_cs_n,
  input  logic [3:0] cmd_io_out,
  input  logic [3:0] cmd_io_oe,
  output logic       pin_sclk,
  output logic       pin_cs_n,
  output logic [3:0] pin_io_out,
  output logic [3:0] pin_io_oe
);
  always_comb begin
    if (sel_mm) begin
      pin_sclk   = mm_sclk;
      pin_cs_n   = mm_cs_n;
      pin_io_out = mm_io_out;
      pin_io_oe  = mm_io_oe;
    end else begin
      pin_sclk   = cmd_sclk;
      pin_cs_n   = cmd_cs_n;
      pin_io_out = cmd_io_out;
      pin_io_oe  = cmd_io_oe;
    end
  end
endmodule

// File: rtl/mmspi_read_xlate.sv
module mmspi_read_xlate
  import mmspi_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_setup,
  input  logic              cfg_mm_en,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [23:0]       rd_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  input  logic              cmd_sclk,
  input  logic              cmd_cs_n,
  input  logic [3:0]        cmd_io_out,
  input  logic [3:0]        cmd_io_oe,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_in
);
  localparam int ADDR_W = 8 * MAX_ADDR_BYTES;
  localparam int TX_W   = 8 + ADDR_W;
  localparam int CNT_W  = $clog2(DATA_W + 64);

  rd_cfg_t           rc;
  xs_state_e         state_q;
  logic              cs_q, sclk_q, err_q;
  logic [TX_W-1:0]   tx_q;
  logic [CNT_W-1:0]  cnt_q, dum_q;
  logic [1:0]        lane_lg_q;
  logic              busy, tick, accept, cfg_ok, last_bit;
  logic [ADDR_W-1:0] addr_al;
  logic [CNT_W-1:0]  tx_len, dummy_len, rx_len;
  logic [DATA_W-1:0] word;
  logic [3:0]        mm_io_out, mm_io_oe;

  assign rc        = decode_setup(cfg_setup);
  assign busy      = (state_q == XS_TX) || (state_q == XS_DUMMY) || (state_q == XS_RX);
  assign rd_ready  = (state_q == XS_IDLE);
  assign accept    = rd_valid && rd_ready;
  assign cfg_ok    = cfg_mm_en && (|cfg_setup);
  assign addr_al   = rd_addr << {2'd3 - rc.addr_bytes, 3'b000};
  assign tx_len    = CNT_W'(8) + CNT_W'({rc.addr_bytes, 3'b000});
  assign dummy_len = CNT_W'({rc.dummy_bytes, 3'b000}) + CNT_W'(rc.dummy_bits);
  assign rx_len    = CNT_W'(DATA_W) >> lane_lg_q;
  assign last_bit  = (cnt_q == CNT_W'(1));

  mmspi_sclk_div #(.SCLK_HALF(SCLK_HALF)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= XS_IDLE;
      cs_q      <= 1'b1;
      sclk_q    <= 1'b0;
      err_q     <= 1'b0;
      tx_q      <= '0;
      cnt_q     <= '0;
      dum_q     <= '0;
      lane_lg_q <= 2'd0;
    end else begin
      case (state_q)
        XS_IDLE: begin
          if (accept) begin
            if (cfg_ok) begin
              state_q   <= XS_TX;
              cs_q      <= 1'b0;
              sclk_q    <= 1'b0;
              tx_q      <= {rc.rd_op, addr_al};
              cnt_q     <= tx_len;
              dum_q     <= dummy_len;
              lane_lg_q <= lane_lg(rc.rd_type);
              err_q     <= 1'b0;
            end else begin
              state_q <= XS_RESP;
              err_q   <= 1'b1;
            end
          end
        end
        XS_TX, XS_DUMMY, XS_RX: begin
          if (tick) begin
            sclk_q <= !sclk_q;
            if (sclk_q) begin
              // falling edge: advance the bit stream
              if (state_q == XS_TX) tx_q <= tx_q << 1;
              if (!last_bit) begin
                cnt_q <= cnt_q - 1'b1;
              end else if (state_q == XS_TX) begin
                if (dum_q != '0) begin
                  state_q <= XS_DUMMY;
                  cnt_q   <= dum_q;
                end else begin
                  state_q <= XS_RX;
                  cnt_q   <= rx_len;
                end
              end else if (state_q == XS_DUMMY) begin
                state_q <= XS_RX;
                cnt_q   <= rx_len;
              end else begin
                state_q <= XS_RESP;
                cs_q    <= 1'b1;
              end
            end
          end
        end
        XS_RESP: begin
          if (rsp_ready) state_q <= XS_IDLE;
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  mmspi_rx_gather #(.DATA_W(DATA_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept),
    .sample (tick && !sclk_q && (state_q == XS_RX)),
    .lane_lg(lane_lg_q),
    .io_in  (spi_io_in),
    .word   (word)
  );

  assign rsp_valid = (state_q == XS_RESP);
  assign rsp_err   = err_q;
  assign rsp_data  = err_q ? '0 : word;
  assign mm_io_out = {3'b000, tx_q[TX_W-1] & (state_q == XS_TX)};
  assign mm_io_oe  = (state_q == XS_TX) ? 4'b0001 : 4'b0000;

  mmspi_pin_mux u_mux (
    .sel_mm    (cfg_mm_en || busy),
    .mm_sclk   (sclk_q),
    .mm_cs_n   (cs_q),
    .mm_io_out (mm_io_out),
    .mm_io_oe  (mm_io_oe),
    .cmd_sclk  (cmd_sclk),
    .cmd_cs_n  (cmd_cs_n),
    .cmd_io_out(cmd_io_out),
    .cmd_io_oe (cmd_io_oe),
    .pin_sclk  (spi_sclk),
    .pin_cs_n  (spi_cs_n),
    .pin_io_out(spi_io_out),
    .pin_io_oe (spi_io_oe)
  );
endmodule

// File: rtl/mmspi_read_xlate_sva.sv
module mmspi_read_xlate_sva
  import mmspi_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_mm_en,
  input logic              rd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_err,
  input xs_state_e         state,
  input logic              mm_cs_n,
  input logic              mm_sclk,
  input logic [3:0]        mm_io_oe,
  input logic              spi_cs_n,
  input logic              spi_sclk,
  input logic              cmd_cs_n,
  input logic              cmd_sclk
);
  p_hold_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));

  p_no_accept_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rd_ready);

  p_lane0_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_io_oe & 4'b1110) == 4'b0000);

  p_dummy_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == XS_DUMMY |-> mm_io_oe == 4'b0000);

  p_idle_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XS_IDLE || state == XS_RESP) |-> mm_cs_n && !mm_sclk);

  p_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> mm_cs_n);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_data == '0 && mm_cs_n);

  p_cmd_owns_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mm_en && mm_cs_n && !mm_sclk |-> spi_cs_n == cmd_cs_n && spi_sclk == cmd_sclk);

  p_keep_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mm_cs_n |-> !spi_cs_n && spi_sclk == mm_sclk);
endmodule

bind mmspi_read_xlate mmspi_read_xlate_sva #(.DATA_W(DATA_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_mm_en(cfg_mm_en),
  .rd_ready (rd_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .rsp_err  (rsp_err),
  .state    (state_q),
  .mm_cs_n  (cs_q),
  .mm_sclk  (sclk_q),
  .mm_io_oe (mm_io_oe),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk),
  .cmd_cs_n (cmd_cs_n),
  .cmd_sclk (cmd_sclk)
);

// File: tb/mmspi_read_xlate_tb.sv
module mmspi_read_xlate_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   cfg_setup = 32'h0;
  logic          cfg_mm_en = 1'b0;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic [23:0]   rd_addr = 24'h0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic          rsp_err;
  logic          cmd_sclk = 1'b0;
  logic          cmd_cs_n = 1'b1;
  logic [3:0]    cmd_io_out = 4'h0;
  logic [3:0]    cmd_io_oe = 4'h0;
  logic          spi_sclk, spi_cs_n;
  logic [3:0]    spi_io_out, spi_io_oe;
  logic [3:0]    spi_io_in = 4'h0;

  // 50 MHz: 20 time units per period
  always #10 clk = ~clk;

  mmspi_read_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_mm_en(cfg_mm_en),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .cmd_sclk(cmd_sclk), .cmd_cs_n(cmd_cs_n), .cmd_io_out(cmd_io_out), .cmd_io_oe(cmd_io_oe),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out),
    .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
  );

  int checks = 0;
  int errors = 0;
  bit stall = 1'b0;
  int stall_ctr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fmem(input logic [23:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ a[23:16] ^ 8'h5C;
  endfunction

  function automatic int lanes_of(input logic [31:0] s);
    if (s[13:12] == 2'd1) return 2;
    if (s[13:12] == 2'd3) return 4;
    return 1;
  endfunction

  function automatic int hdr_of(input logic [31:0] s);
    return 8 + 8 * int'(s[9:8]) + 8 * int'(s[11:10]) + int'(s[28:24]);
  endfunction

  // ---------------- flash model ----------------
  int          rise_cnt = 0;
  int          cs_falls = 0;
  int          dummy_oe_bad = 0;
  int          last_rises = 0;
  logic [7:0]  sl_op = 8'h0, last_op = 8'h0;
  logic [23:0] sl_adr = 24'h0, last_adr = 24'h0;

  initial forever begin
    @(negedge spi_cs_n);
    cs_falls++;
    rise_cnt = 0;
    sl_op = 8'h0;
    sl_adr = 24'h0;
    spi_io_in = 4'h0;
  end

  initial forever begin
    @(posedge spi_cs_n);
    last_op = sl_op;
    last_adr = sl_adr;
    last_rises = rise_cnt;
  end

  initial forever begin
    @(posedge spi_sclk);
    if (!spi_cs_n) begin
      if (rise_cnt < 8) sl_op = {sl_op[6:0], spi_io_out[0]};
      else if (rise_cnt < 8 + 8 * int'(cfg_setup[9:8])) sl_adr = {sl_adr[22:0], spi_io_out[0]};
      else if (rise_cnt < hdr_of(cfg_setup) && spi_io_oe != 4'h0) dummy_oe_bad++;
      rise_cnt++;
    end
  end

  initial forever begin
    @(negedge spi_sclk);
    if (!spi_cs_n && rise_cnt >= hdr_of(cfg_setup)) begin
      int l, g, bp;
      logic [7:0] bv;
      logic [3:0] nx;
      l  = lanes_of(cfg_setup);
      g  = (rise_cnt - hdr_of(cfg_setup)) * l;
      bv = fmem(sl_adr + 24'(g / 8));
      bp = g % 8;
      nx = 4'h0;
      if (l == 1) nx[1] = bv[7 - bp];
      else for (int j = 0; j < l; j++) nx[l - 1 - j] = bv[7 - bp - j];
      spi_io_in = nx;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [31:0] data;
    logic        err;
    logic [7:0]  op;
    logic [23:0] adr;
    int          rises;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic rd(input logic [23:0] a, input string tag);
    exp_t e;
    logic [31:0] mask;
    e.tag = tag;
    e.err = !(cfg_mm_en && (cfg_setup != 32'h0));
    e.op  = cfg_setup[7:0];
    mask  = (32'h1 << (8 * int'(cfg_setup[9:8]))) - 32'h1;
    e.adr = a & mask[23:0];
    e.rises = hdr_of(cfg_setup) + 32 / lanes_of(cfg_setup);
    e.data = 32'h0;
    if (!e.err)
      for (int i = 0; i < 4; i++) e.data[8*i +: 8] = fmem(e.adr + 24'(i));
    exp_q.push_back(e);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_addr = a;
    while (!rd_ready) @(negedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_q.size() != 0 || !rd_ready) @(negedge clk);
  endtask

  // response consumer, with optional back-pressure
  initial forever begin
    @(posedge clk);
    #2;
    stall_ctr++;
    rsp_ready = !stall || (stall_ctr % 4 == 0);
  end

  initial forever begin
    @(negedge clk);
    if (rst_n && rsp_valid) begin
      if (!rsp_ready) begin
        chk(!rd_ready, "R1", "rd_ready while response held", 32'(rd_ready), 32'h0);
      end else if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected response", rsp_data, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_err == e.err, e.tag, "rsp_err", 32'(rsp_err), 32'(e.err));
        chk(rsp_data == e.data, e.err ? e.tag : "R5", "rsp_data", rsp_data, e.data);
        if (!e.err) begin
          chk(last_op == e.op, "R2", "opcode seen by flash", 32'(last_op), 32'(e.op));
          chk(last_adr == e.adr, "R2", "address seen by flash", 32'(last_adr), 32'(e.adr));
          chk(last_rises == e.rises, "R3", "SCLK cycles per access", 32'(last_rises), 32'(e.rises));
        end
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_ready == 1'b1, "R1", "rd_ready after reset", 32'(rd_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);

    // R9: command engine owns the pins
    cmd_sclk = 1'b1; cmd_cs_n = 1'b1; cmd_io_out = 4'hA; cmd_io_oe = 4'h5;
    @(negedge clk);
    chk({spi_sclk, spi_cs_n, spi_io_out, spi_io_oe} == 10'b1_1_1010_0101, "R9", "pins pattern A",
        32'({spi_sclk, spi_cs_n, spi_io_out, spi_io_oe}), 32'h3A5);
    cmd_sclk = 1'b0; cmd_io_out = 4'h3; cmd_io_oe = 4'hC;
    @(negedge clk);
    chk({spi_sclk, spi_cs_n, spi_io_out, spi_io_oe} == 10'b0_1_0011_1100, "R9", "pins pattern B",
        32'({spi_sclk, spi_cs_n, spi_io_out, spi_io_oe}), 32'h13C);
    cmd_io_out = 4'h0; cmd_io_oe = 4'h0;

    // R7: read while switch clear
    cfg_setup = 32'h0012_0303;
    snap = cs_falls;
    rd(24'h001234, "R7");
    wait_idle();
    chk(cs_falls == snap, "R7", "chip select falls", 32'(cs_falls), 32'(snap));

    // R8: switch set, setup zero
    cfg_mm_en = 1'b1;
    cfg_setup = 32'h0;
    rd(24'h00ABCD, "R8");
    wait_idle();
    chk(cs_falls == snap, "R8", "chip select falls", 32'(cs_falls), 32'(snap));

    // R6/R9: translator owns idle pins
    cmd_cs_n = 1'b0; cmd_sclk = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R6", "idle pins under translator",
        32'({spi_cs_n, spi_sclk}), 32'h2);
    cmd_cs_n = 1'b1; cmd_sclk = 1'b0;

    // normal single-lane reads
    cfg_setup = 32'h0012_0303;
    snap = cs_falls;
    rd(24'h012345, "R2");
    rd(24'hFFFFFE, "R2");
    wait_idle();
    chk(cs_falls == snap + 2, "R6", "one chip select per access", 32'(cs_falls), 32'(snap + 2));

    // dual lanes, one dummy byte
    cfg_setup = 32'h0000_176B;
    rd(24'h00F0F0, "R4");
    rd(24'h7A5A11, "R4");
    wait_idle();

    // quad lanes, one dummy byte plus three dummy bits
    cfg_setup = 32'h0300_376C;
    dummy_oe_bad = 0;
    rd(24'h123456, "R4");
    wait_idle();
    chk(dummy_oe_bad == 0, "R3", "lanes driven in dummy stretch", 32'(dummy_oe_bad), 32'h0);

    // two address bytes
    cfg_setup = 32'h0000_0203;
    rd(24'hABCDEF, "R2");
    wait_idle();

    // reserved lane code behaves as single lane
    cfg_setup = 32'h0000_2303;
    rd(24'h0055AA, "R4");
    wait_idle();

    // back-pressure on the response channel
    cfg_setup = 32'h0000_376C;
    stall = 1'b1;
    rd(24'h000100, "R1");
    rd(24'h000200, "R1");
    wait_idle();
    stall = 1'b0;

    // R10: switch cleared mid-access
    cfg_setup = 32'h0012_0303;
    cmd_cs_n = 1'b1;
    rd(24'h0C0FFE, "R10");
    repeat (10) @(negedge clk);
    cfg_mm_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(spi_cs_n == 1'b0, "R10", "chip select kept during access", 32'(spi_cs_n), 32'h0);
    end
    wait_idle();
    chk(spi_cs_n == cmd_cs_n, "R10", "pins handed back", 32'(spi_cs_n), 32'(cmd_cs_n));
    snap = cs_falls;
    rd(24'h000010, "R7");
    wait_idle();
    chk(cs_falls == snap, "R7", "no SPI activity after hand-back", 32'(cs_falls), 32'(snap));

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule